// File: doc/BRIEF.md
# Glitch-Free Two-Source Clock Switcher

This block selects one of two unrelated clocks, an on-chip clock and an off-chip clock, and drives one output clock whose pulses are never cut short. A select request is taken only when both sources are enabled and the target reports stable. Two override inputs can force either source regardless of that guard. The internal override is asserted during reset, so the internal clock is the reset default.

Each source has its own gate-enable chain, clocked by that source. The first stage samples on the rising edge and the following stages sample on the falling edge. A chain may start to open only after the opposite chain is seen to be completely empty. An off input for each source closes that source's gate through its own chain. The output is the OR of the two gated clocks. A second output toggles on every rising edge of the output clock, which gives the selected clock divided by two.

Top module: `clock_switcher`

## Requirements
- R1: While `rstN` is low, `clkOut` and `clkDiv2` are both 0. After reset is released with `forceInt` high, `clkOut` follows `intClk`.
- R2: Outside the overrides, a new `selReq` value is taken only when `intOn` and `extOn` are both 1 and the target's stable flag is 1. Otherwise the current source is kept and the output carries no gap.
- R3: `forceInt` high selects the internal clock and takes priority over everything else. `forceExt` high, with `forceInt` low, selects the external clock without regard to the guard.
- R4: After a change is accepted, the old clock reaches the output for at most two more of its own cycles. The output then stays low for more than one and at most two periods of the new clock before the new clock's first pulse (default sync depth 2).
- R5: No high or low phase of `clkOut` is shorter than half the period of the faster source.
- R6: The two gate enables are never open at the same time, and each enable changes only while its own clock is low.
- R7: With `intOff` or `extOff` high, the corresponding source is kept from `clkOut`. When the selected source is off, the output stays low. The output resumes once the off input returns to 0.
- R8: `clkDiv2` is 0 out of reset and toggles exactly once per rising edge of `clkOut`.
- R9: The encoding of `selReq` is 0 for internal and 1 for external. In steady state `clkOut` is equal to the selected clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| intClk | input | 1 | Internal source clock; also clocks the select register |
| extClk | input | 1 | External source clock |
| rstN | input | 1 | Asynchronous active-low reset |
| selReq | input | 1 | Requested source: 0 internal, 1 external |
| forceInt | input | 1 | Override to internal (priority) |
| forceExt | input | 1 | Override to external |
| intOff | input | 1 | Blocks the internal clock from the output |
| extOff | input | 1 | Blocks the external clock from the output |
| intOn | input | 1 | Internal source enabled |
| extOn | input | 1 | External source enabled |
| intStable | input | 1 | Internal source stable |
| extStable | input | 1 | External source stable |
| clkOut | output | 1 | Glitch-free selected clock |
| clkDiv2 | output | 1 | Selected clock divided by two |

## Verification
A select request is registered on the first rising edge of `intClk` that follows it. The handover gap then closes within two new-clock periods. For that reason every switch is followed by a settling window of twenty periods of the slower clock before the output is compared with the selected source. The gap length is taken as the longest low phase measured inside that window and must fall within one to two new-clock periods. Following checks sample a quarter period after each source edge, which keeps them clear of the gating flops. Off and override checks wait several source cycles before they sample, because the three-edge chain must first settle.

// File: rtl/cs_pkg.sv
package cs_pkg;

  // Strobes from the selection control to the gating datapath
  typedef struct packed {
    logic useInt;
    logic useExt;
  } csStrobes_t;

  localparam int unsigned CS_PATHS   = 2;
  localparam int unsigned CS_IDX_INT = 0;
  localparam int unsigned CS_IDX_EXT = 1;

endpackage

// File: rtl/cs_path.sv
// One gate-enable chain for one source clock.
module cs_path #(
  parameter int unsigned STAGES = 2
) (
  input  logic pathClk,
  input  logic rstN,
  input  logic wantOn,
  input  logic otherBusy,
  output logic gateEn,
  output logic busy,
  output logic gatedClk
);

  localparam int unsigned TAIL = (STAGES < 2) ? 1 : STAGES - 1;

  logic            stage0;
  logic [TAIL-1:0] tail;

  // first stage samples the request on the rising edge
  always_ff @(posedge pathClk or negedge rstN) begin
    if (!rstN) stage0 <= 1'b0;
    else       stage0 <= wantOn & ~otherBusy;
  end

  // remaining stages move only on the falling edge, so the gate never truncates a high phase
  always_ff @(negedge pathClk or negedge rstN) begin
    if (!rstN) begin
      tail <= '0;
    end else begin
      tail[0] <= stage0;
      for (int i = 1; i < TAIL; i++) tail[i] <= tail[i-1];
    end
  end

  assign gateEn   = tail[TAIL-1];
  assign busy     = stage0 | (|tail);
  assign gatedClk = pathClk & gateEn;

endmodule

// File: rtl/cs_ctrl.sv
// Selection control: guard, overrides and off qualifiers.
module cs_ctrl
  import cs_pkg::*;
(
  input  logic       intClk,
  input  logic       rstN,
  input  logic       selReq,
  input  logic       forceInt,
  input  logic       forceExt,
  input  logic       intOff,
  input  logic       extOff,
  input  logic       intOn,
  input  logic       extOn,
  input  logic       intStable,
  input  logic       extStable,
  output logic       selQ,
  output csStrobes_t strobes
);

  logic guardOk;
  logic selNext;

  assign guardOk = intOn & extOn & (selReq ? extStable : intStable);

  always_comb begin
    if (forceInt)      selNext = 1'b0;
    else if (forceExt) selNext = 1'b1;
    else if (guardOk)  selNext = selReq;
    else               selNext = selQ;
  end

  always_ff @(posedge intClk or negedge rstN) begin
    if (!rstN) selQ <= 1'b0;
    else       selQ <= selNext;
  end

  assign strobes.useInt = ~selQ & ~intOff;
  assign strobes.useExt =  selQ & ~extOff;

endmodule

// File: rtl/cs_datapath.sv
// Gating datapath: two interlocked chains, output OR and divider.
module cs_datapath
  import cs_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic       intClk,
  input  logic       extClk,
  input  logic       rstN,
  input  csStrobes_t strobes,
  output logic       clkOut,
  output logic       clkDiv2,
  output logic       intGateEn,
  output logic       extGateEn
);

  logic [CS_PATHS-1:0] srcClk;
  logic [CS_PATHS-1:0] want;
  logic [CS_PATHS-1:0] busy;
  logic [CS_PATHS-1:0] gate;
  logic [CS_PATHS-1:0] gated;
  logic                divQ;

  assign srcClk[CS_IDX_INT] = intClk;
  assign srcClk[CS_IDX_EXT] = extClk;
  assign want[CS_IDX_INT]   = strobes.useInt;
  assign want[CS_IDX_EXT]   = strobes.useExt;

  for (genvar g = 0; g < CS_PATHS; g++) begin : gPath
    cs_path #(.STAGES(SYNC_DEPTH)) u_path (
      .pathClk  (srcClk[g]),
      .rstN     (rstN),
      .wantOn   (want[g]),
      .otherBusy(busy[CS_PATHS-1-g]),
      .gateEn   (gate[g]),
      .busy     (busy[g]),
      .gatedClk (gated[g])
    );
  end

  assign clkOut    = |gated;
  assign intGateEn = gate[CS_IDX_INT];
  assign extGateEn = gate[CS_IDX_EXT];

  always_ff @(posedge clkOut or negedge rstN) begin
    if (!rstN) divQ <= 1'b0;
    else       divQ <= ~divQ;
  end

  assign clkDiv2 = divQ;

endmodule

// File: rtl/clock_switcher.sv
module clock_switcher
  import cs_pkg::*;
#(
  parameter int unsigned SYNC_DEPTH = 2
) (
  input  logic intClk,
  input  logic extClk,
  input  logic rstN,
  input  logic selReq,
  input  logic forceInt,
  input  logic forceExt,
  input  logic intOff,
  input  logic extOff,
  input  logic intOn,
  input  logic extOn,
  input  logic intStable,
  input  logic extStable,
  output logic clkOut,
  output logic clkDiv2
);

  csStrobes_t strobes;
  logic       selQ;
  logic       intGateEn;
  logic       extGateEn;

  cs_ctrl u_ctrl (
    .intClk   (intClk),
    .rstN     (rstN),
    .selReq   (selReq),
    .forceInt (forceInt),
    .forceExt (forceExt),
    .intOff   (intOff),
    .extOff   (extOff),
    .intOn    (intOn),
    .extOn    (extOn),
    .intStable(intStable),
    .extStable(extStable),
    .selQ     (selQ),
    .strobes  (strobes)
  );

  cs_datapath #(.SYNC_DEPTH(SYNC_DEPTH)) u_dp (
    .intClk   (intClk),
    .extClk   (extClk),
    .rstN     (rstN),
    .strobes  (strobes),
    .clkOut   (clkOut),
    .clkDiv2  (clkDiv2),
    .intGateEn(intGateEn),
    .extGateEn(extGateEn)
  );

endmodule

// File: rtl/cs_checker.sv
module cs_checker (
  input logic intClk,
  input logic extClk,
  input logic rstN,
  input logic forceInt,
  input logic forceExt,
  input logic intOn,
  input logic extOn,
  input logic selQ,
  input logic intGateEn,
  input logic extGateEn,
  input logic clkOut,
  input logic clkDiv2
);

  // R3
  force_int_chk: assert property (@(posedge intClk) disable iff (!rstN)
    forceInt |=> !selQ);

  // R3
  force_ext_chk: assert property (@(posedge intClk) disable iff (!rstN)
    (forceExt && !forceInt) |=> selQ);

  // R2
  guard_hold_chk: assert property (@(posedge intClk) disable iff (!rstN)
    (!forceInt && !forceExt && !(intOn && extOn)) |=> $stable(selQ));

  // R6
  mutex_int_chk: assert property (@(posedge intClk) disable iff (!rstN)
    !(intGateEn && extGateEn));

  // R6
  mutex_ext_chk: assert property (@(posedge extClk) disable iff (!rstN)
    !(intGateEn && extGateEn));

  // R6
  always @(intGateEn) begin
    if (rstN === 1'b1) int_gate_edge_chk: assert (intClk == 1'b0);
  end

  // R6
  always @(extGateEn) begin
    if (rstN === 1'b1) ext_gate_edge_chk: assert (extClk == 1'b0);
  end

  // R8
  div_toggle_chk: assert property (@(posedge clkOut) disable iff (!rstN)
    rstN |=> (clkDiv2 != $past(clkDiv2)));

endmodule

bind clock_switcher cs_checker u_chk (.*);

// File: tb/sim_clock_switcher.sv
`timescale 1ns/1ps
module sim_clock_switcher;

  logic intClk = 1'b0, extClk = 1'b0, rstN = 1'b0;
  logic selReq = 1'b0, forceInt = 1'b1, forceExt = 1'b0;
  logic intOff = 1'b0, extOff = 1'b0, intOn = 1'b1, extOn = 1'b1;
  logic intStable = 1'b1, extStable = 1'b1;
  logic clkOut, clkDiv2;

  real extHalf  = 6.9;
  real lastEdge = 0.0;
  real minPhase = 1.0e9;
  real maxLow   = 0.0;
  bit  monOn    = 1'b0;
  bit  finished = 1'b0;
  int  nChecks  = 0;
  int  nFails   = 0;
  int  outRises = 0;
  int  divEdges = 0;

  clock_switcher u0 (
    .intClk(intClk), .extClk(extClk), .rstN(rstN), .selReq(selReq),
    .forceInt(forceInt), .forceExt(forceExt), .intOff(intOff), .extOff(extOff),
    .intOn(intOn), .extOn(extOn), .intStable(intStable), .extStable(extStable),
    .clkOut(clkOut), .clkDiv2(clkDiv2)
  );

  always #5 intClk = ~intClk;

  initial begin
    real ph;
    ph = $urandom_range(0, 999) / 100.0;
    #(ph);
    forever #(extHalf) extClk = ~extClk;
  end

  // phase monitor on the output clock
  always @(clkOut) begin
    real d;
    d = $realtime - lastEdge;
    if (monOn) begin
      if (d < minPhase) minPhase = d;
      if (clkOut && d > maxLow) maxLow = d;
    end
    lastEdge = $realtime;
    if (clkOut && rstN) outRises++;
  end

  always @(clkDiv2) if (rstN) divEdges++;

  task automatic chk(input bit ok, input string req, input string act, input string exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %s expected %s", req, act, exp);
    end
  endtask

  task automatic follow(input bit useExt, input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (useExt) begin
        @(posedge extClk); #(extHalf / 2.0); if (clkOut !== 1'b1) bad++;
        @(negedge extClk); #(extHalf / 2.0); if (clkOut !== 1'b0) bad++;
      end else begin
        @(posedge intClk); #2.5; if (clkOut !== 1'b1) bad++;
        @(negedge intClk); #2.5; if (clkOut !== 1'b0) bad++;
      end
    end
    chk(bad == 0, req, $sformatf("%0d mismatched samples", bad), "0 mismatched samples");
  endtask

  task automatic quiet(input int n, input string req);
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      #1; if (clkOut !== 1'b0) bad++;
    end
    chk(bad == 0, req, $sformatf("%0d high samples", bad), "0 high samples");
  endtask

  function automatic real slowPeriod();
    return (2.0 * extHalf > 10.0) ? 2.0 * extHalf : 10.0;
  endfunction

  task automatic gapSwitch(input bit target);
    real tn;
    tn = target ? 2.0 * extHalf : 10.0;
    #($urandom_range(0, 97) / 10.0);
    maxLow = 0.0;
    selReq = target;
    #(20.0 * slowPeriod());
    chk(maxLow > tn - 0.05 && maxLow <= 2.0 * tn + 0.05, "R4 handover gap",
        $sformatf("%0.2f ns", maxLow), $sformatf("(%0.2f, %0.2f] ns", tn, 2.0 * tn));
    follow(target, 6, "R9 steady output equals selected source");
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  endtask

  initial begin
    #1500000;
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      finishRun();
    end
  end

  initial begin
    real halves [3];
    int  o0, d0;
    halves[0] = 3.7; halves[1] = 6.9; halves[2] = 11.3;

    // R1 reset state
    #13;
    quiet(20, "R1 output low in reset");
    chk(clkDiv2 === 1'b0, "R1 R8 divider low in reset", $sformatf("%b", clkDiv2), "0");
    rstN = 1'b1;
    #3 forceInt = 1'b0;
    #40 monOn = 1'b1;
    follow(1'b0, 10, "R1 internal source after reset");

    // R4 R5 sweep over external periods, both directions
    foreach (halves[k]) begin
      extHalf = halves[k];
      #60;
      minPhase = 1.0e9;
      repeat (2) begin
        gapSwitch(1'b1);
        gapSwitch(1'b0);
      end
      chk(minPhase >= ((extHalf < 5.0) ? extHalf : 5.0) - 0.02, "R5/R6 minimum phase",
          $sformatf("%0.2f ns", minPhase),
          $sformatf(">= %0.2f ns", (extHalf < 5.0) ? extHalf : 5.0));
    end

    extHalf = 6.9;
    #60;

    // R2 target not stable
    extStable = 1'b0; maxLow = 0.0; selReq = 1'b1;
    #200;
    chk(maxLow <= 5.05, "R2 rejected request leaves no gap", $sformatf("%0.2f ns", maxLow), "<= 5.00 ns");
    follow(1'b0, 8, "R2 unstable target keeps internal");
    selReq = 1'b0; extStable = 1'b1;
    #40;

    // R2 one source disabled
    intOn = 1'b0; selReq = 1'b1;
    #200;
    follow(1'b0, 8, "R2 disabled source blocks switch");
    selReq = 1'b0; intOn = 1'b1;
    #40;

    // R2 switch back refused when internal not stable
    gapSwitch(1'b1);
    intStable = 1'b0; selReq = 1'b0;
    #200;
    follow(1'b1, 8, "R2 unstable internal keeps external");
    intStable = 1'b1;
    gapSwitch(1'b0);

    // R3 overrides
    extStable = 1'b0; forceExt = 1'b1;
    #300;
    follow(1'b1, 8, "R3 force external overrides guard");
    forceInt = 1'b1;
    #300;
    follow(1'b0, 8, "R3 force internal has priority");
    forceInt = 1'b0; forceExt = 1'b0; extStable = 1'b1;
    #200;
    follow(1'b0, 6, "R3 release keeps internal");

    // R7 off qualifiers
    intOff = 1'b1;
    #50;
    quiet(100, "R7 internal off blocks output");
    intOff = 1'b0;
    #50;
    follow(1'b0, 6, "R7 internal resumes");
    gapSwitch(1'b1);
    extOff = 1'b1;
    #80;
    quiet(100, "R7 external off blocks output");
    extOff = 1'b0;
    #80;
    follow(1'b1, 6, "R7 external resumes");

    // R8 divider tracks every rising edge
    @(negedge clkOut); #0.5;
    o0 = outRises; d0 = divEdges;
    #600;
    @(negedge clkOut); #0.5;
    chk((outRises - o0) == (divEdges - d0), "R8 divider toggles per rise",
        $sformatf("%0d toggles", divEdges - d0), $sformatf("%0d toggles", outRises - o0));

    finished = 1'b1;
    finishRun();
  end

endmodule